// File: doc/BRIEF.md
# Multiword Add-With-Carry Unit

This block is the integer add stage of an in-order core, extended so that software can add numbers wider than one 64-bit register. It offers two ways of carrying between limbs. In the register style, a three-input add sums two operands and a third register holding the incoming carry. A companion operation runs the same three-input sum and returns only its carry-out, as a 0 or 1 value in a register. In the flag style, a single internal carry bit is both the carry-in and the carry-out of an add. A clear operation zeroes that bit so that a new chain can start.

The datapath stays 64 bits wide. A carry never lives as an extra register bit. One operation is accepted per strobe, and its result and any flag change appear together one clock later. A 256-bit sum is built from four limbs, least significant first. The last carry gives bit 256.

Top module: `madd_unit`

## Requirements
- R1: With opcode 2'b00 (three-input add), the result is the low 64 bits of opA + opB + opC.
- R2: With opcode 2'b01 (carry generate), the result is 1 when opA + opB + opC is 2^64 or more, and 0 otherwise. Bits 63..1 of the result are always zero.
- R3: With opcode 2'b10 (flag add), the result is the low 64 bits of opA + opB + flagT, and flagT takes the carry-out of that sum. opC has no effect.
- R4: Opcodes 2'b00 and 2'b01, and cycles without a strobe, leave flagT unchanged.
- R5: Opcode 2'b11 (clear) sets flagT to 0 and gives a result of 0.
- R6: outValid is high exactly in the cycle after a cycle with inValid high. The result and flagT change at that same edge, and the result holds its value while no operation is accepted.
- R7: A synchronous reset clears flagT, outValid and result to 0.
- R8: Four chained limbs in either style produce the 257-bit sum of two 256-bit operands: the four results are bits 255..0, and the final carry (a generate result, or flagT) is bit 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept an operation this cycle |
| op | input | 2 | Opcode: 00 add3, 01 carry generate, 10 flag add, 11 clear flag |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opC | input | 64 | Third operand (carry-in register for add3 and carry generate) |
| outValid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| flagT | output | 1 | Current carry flag |

## Verification
Every result, and every flag change, is due at the first rising edge after the strobe. So each operation is driven on a falling edge, the strobe is dropped on the next falling edge, and result, outValid and flagT are sampled there, half a period after the edge that loaded them. The tests that check flag holding and strobe-free cycles sample one full cycle later, once no operation is pending. In this way each check sees exactly one register stage between stimulus and sample.

// File: rtl/addc_pkg.sv
package addc_pkg;

  typedef enum logic [1:0] {
    OP_ADD3 = 2'b00,
    OP_GENC = 2'b01,
    OP_ADDT = 2'b10,
    OP_CLRT = 2'b11
  } addc_op_e;

  typedef struct packed {
    logic valid;
    logic selGen;
    logic selFlag;
    logic selZero;
    logic flagWrite;
  } addc_ctrl_t;

endpackage

// File: rtl/addc_ctrl.sv
module addc_ctrl
  import addc_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opIn,
  output addc_ctrl_t ctrl
);
  addc_op_e opDec;

  always_comb begin
    opDec = addc_op_e'(opIn);
    ctrl = '0;
    ctrl.valid = inValid;
    unique case (opDec)
      OP_ADD3: ;
      OP_GENC: ctrl.selGen = 1'b1;
      OP_ADDT: begin
        ctrl.selFlag   = 1'b1;
        ctrl.flagWrite = inValid;
      end
      OP_CLRT: begin
        ctrl.selZero   = 1'b1;
        ctrl.flagWrite = inValid;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/addc_dp.sv
module addc_dp
  import addc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  addc_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             flagT
);
  localparam int SUM3W = WIDTH + 2;
  localparam int SUMTW = WIDTH + 1;

  logic [SUM3W-1:0] sum3;
  logic [SUMTW-1:0] sumT;
  logic [WIDTH-1:0] resNext;
  logic             flagNext;

  always_comb begin
    sum3 = {2'b00, opA} + {2'b00, opB} + {2'b00, opC};
    sumT = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, flagT};
    if (ctrl.selZero) begin
      resNext  = '0;
      flagNext = 1'b0;
    end else if (ctrl.selFlag) begin
      resNext  = sumT[WIDTH-1:0];
      flagNext = sumT[WIDTH];
    end else if (ctrl.selGen) begin
      resNext  = {{(WIDTH-1){1'b0}}, |sum3[SUM3W-1:WIDTH]};
      flagNext = flagT;
    end else begin
      resNext  = sum3[WIDTH-1:0];
      flagNext = flagT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
      flagT    <= 1'b0;
    end else begin
      outValid <= ctrl.valid;
      if (ctrl.valid) result <= resNext;
      if (ctrl.flagWrite) flagT <= flagNext;
    end
  end
endmodule

// File: rtl/madd_unit.sv
module madd_unit
  import addc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             flagT
);
  addc_ctrl_t ctrl;

  addc_ctrl u_ctrl (
    .inValid(inValid),
    .opIn   (op),
    .ctrl   (ctrl)
  );

  addc_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .opC     (opC),
    .outValid(outValid),
    .result  (result),
    .flagT   (flagT)
  );
endmodule

// File: rtl/addc_chk.sv
module addc_chk
  import addc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [1:0]       op,
  input logic             outValid,
  input logic [WIDTH-1:0] result,
  input logic             flagT
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(result) && $stable(flagT))); // R6
  AST_GEN_BINARY: assert property (@(posedge clk) disable iff (rst)
    (inValid && op == OP_GENC) |=> (result[WIDTH-1:1] == '0)); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inValid && (op == OP_ADD3 || op == OP_GENC)) |=> $stable(flagT)); // R4
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (inValid && op == OP_CLRT) |=> (!flagT && result == '0)); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!flagT && !outValid && result == '0)); // R7
endmodule

bind madd_unit addc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .op      (op),
  .outValid(outValid),
  .result  (result),
  .flagT   (flagT)
);

// File: tb/sim_madd_unit.sv
module sim_madd_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [63:0] opA = '0, opB = '0, opC = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flagT;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  madd_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .op(op),
    .opA(opA), .opB(opB), .opC(opC),
    .outValid(outValid), .result(result), .flagT(flagT)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkWide(input string req, input logic [256:0] act, input logic [256:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge.
  task automatic issue(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] c);
    @(negedge clk);
    inValid = 1'b1; op = o; opA = a; opB = b; opC = c;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic testReset();
    chk("R7 flag after reset", {63'd0, flagT}, 64'd0);
    chk("R7 valid after reset", {63'd0, outValid}, 64'd0);
    chk("R7 result after reset", result, 64'd0);
  endtask

  task automatic testAdd3();
    logic [63:0] a = rnd64(), b = rnd64();
    issue(2'b00, a, b, 64'd1);
    chk("R1 add3 random", result, a + b + 64'd1);
    chk("R6 valid one cycle later", {63'd0, outValid}, 64'd1);
    issue(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd5);
    chk("R1 add3 wrap", result, 64'd5);
  endtask

  task automatic testGen();
    issue(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1);
    chk("R2 gen exact 2^64", result, 64'd1);
    issue(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0);
    chk("R2 gen no carry", result, 64'd0);
    issue(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 gen double carry", result, 64'd1);
  endtask

  task automatic testFlag();
    issue(2'b11, 64'd7, 64'd7, 64'd7);
    chk("R5 clear result", result, 64'd0);
    chk("R5 clear flag", {63'd0, flagT}, 64'd0);
    issue(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'hDEAD);
    chk("R3 flag add sum, opC ignored", result, 64'd1);
    chk("R3 flag add carry out", {63'd0, flagT}, 64'd1);
    issue(2'b00, 64'd1, 64'd2, 64'd0);
    chk("R4 add3 keeps flag", {63'd0, flagT}, 64'd1);
    issue(2'b01, 64'd0, 64'd0, 64'd0);
    chk("R4 gen keeps flag", {63'd0, flagT}, 64'd1);
    issue(2'b10, 64'd10, 64'd20, 64'd0);
    chk("R3 flag add uses carry in", result, 64'd31);
    chk("R3 flag cleared by no carry", {63'd0, flagT}, 64'd0);
    issue(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    @(negedge clk);
    chk("R6 idle drops valid", {63'd0, outValid}, 64'd0);
    chk("R6 idle holds result", result, 64'd0);
    chk("R4 idle keeps flag", {63'd0, flagT}, 64'd1);
  endtask

  task automatic chainReg(input logic [255:0] A, input logic [255:0] B, input string tag);
    logic [256:0] got;
    logic [63:0] carry = 64'd0;
    for (int i = 0; i < 4; i++) begin
      issue(2'b00, A[i*64 +: 64], B[i*64 +: 64], carry);
      got[i*64 +: 64] = result;
      issue(2'b01, A[i*64 +: 64], B[i*64 +: 64], carry);
      carry = result;
    end
    got[256] = carry[0];
    chkWide({"R8 register chain ", tag}, got, {1'b0, A} + {1'b0, B});
  endtask

  task automatic chainFlag(input logic [255:0] A, input logic [255:0] B, input string tag);
    logic [256:0] got;
    issue(2'b11, 64'd0, 64'd0, 64'd0);
    for (int i = 0; i < 4; i++) begin
      issue(2'b10, A[i*64 +: 64], B[i*64 +: 64], 64'd0);
      got[i*64 +: 64] = result;
    end
    got[256] = flagT;
    chkWide({"R8 flag chain ", tag}, got, {1'b0, A} + {1'b0, B});
  endtask

  task automatic testChains();
    logic [255:0] ones = '1;
    logic [255:0] A, B;
    chainReg(ones, ones, "all-ones");
    chainFlag(ones, ones, "all-ones");
    chainReg(ones, 256'd1, "ripple");
    chainFlag(ones, 256'd1, "ripple");
    for (int k = 0; k < 4; k++) begin
      A = {rnd64(), rnd64(), rnd64(), rnd64()};
      B = {rnd64(), rnd64(), rnd64(), rnd64()};
      chainReg(A, B, "random");
      chainFlag(A, B, "random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAdd3();
    testGen();
    testFlag();
    testChains();
    issue(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    testReset();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule